// File: doc/BRIEF.md
# Buffer-to-FIFO Read Engine

This block copies a buffer of 32-bit sample words, held in host memory, into a local output FIFO. Software first loads a start address and then a word count. Writing the count starts the engine if it is idle and enabled. The engine then reads words one at a time at rising addresses over a simple request/response bus. It places each returned word on a valid/ready push port toward the FIFO. A plain status word reports whether the engine is idle, whether it is working, whether the buffer has run out, and whether a bus error has occurred.

Only one read is in flight at a time. The FIFO side follows valid/ready rules: `fifo_valid` rises with a word and stays high, with `fifo_data` unchanged, until a cycle where `fifo_ready` is high. While `fifo_ready` is low the engine treats the FIFO as full and starts no new read. The request side offers `rd_req_valid` and waits for `rd_req_ready`. The response side raises `rd_rsp_ready` only while it waits for the data of the accepted read, and it takes the response in the first cycle where `rd_rsp_valid` is also high.

The two sticky flags clear under different rules. The buffer-end flag clears when a new count is accepted. The bus-error flag freezes the engine and stays set until `enable` is dropped.

Top module: `bufrd_ctrl`

## Requirements
- R1: After reset the engine is idle and `status` equals 0x0001_0000.
- R2: A count write (`cfg_len_we`) starts a transfer only when `enable` is high and the engine is idle. The next cycle shows busy. Count writes while busy, while halted or while disabled are ignored.
- R3: Read k of a buffer (k from 0) uses address base+4k, where base is the last value written with `cfg_addr_we`. After a read is accepted, no new request is offered until its response has been taken.
- R4: Each good response word is presented on the FIFO port in read order. It is held valid and stable until `fifo_ready` is high.
- R5: While `fifo_ready` is low, `rd_req_valid` stays low.
- R6: When the FIFO accepts the last word of the buffer, the buffer-end flag is set and the engine returns to idle in the next cycle.
- R7: An accepted count write clears the buffer-end flag. A count of zero issues no read and sets the flag in the next cycle.
- R8: A response with `rd_rsp_err` nonzero (01 no target answered, 10 target fatal error; 00 means good) sets the error flag and halts the engine. While halted, no read is issued and both busy and idle read 0.
- R9: With `enable` low, the engine is idle in the next cycle, the error flag is clear, and any words not yet transferred are dropped.
- R10: `status` has buffer-end at bit 20, error at bit 18, busy at bit 17 and idle at bit 16. All other bits read 0, and busy and idle are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Engine enable; low forces idle and clears the error flag |
| cfg_addr_we | input | 1 | Write strobe for the start address |
| cfg_addr | input | ADDR_W | Buffer start address (byte address, word aligned) |
| cfg_len_we | input | 1 | Write strobe for the word count; starts a transfer |
| cfg_len | input | LEN_W | Buffer length in words |
| rd_req_valid | output | 1 | Read request offered |
| rd_req_ready | input | 1 | Bus accepts the request |
| rd_req_addr | output | ADDR_W | Read address |
| rd_rsp_valid | input | 1 | Response present |
| rd_rsp_ready | output | 1 | Engine waits for a response |
| rd_rsp_data | input | DATA_W | Response data |
| rd_rsp_err | input | 2 | Response code: 00 good, 01 no target, 10 target error |
| fifo_valid | output | 1 | Word offered to the FIFO |
| fifo_ready | input | 1 | FIFO has room |
| fifo_data | output | DATA_W | Word to the FIFO |
| status | output | 32 | Status word |

## Verification
The hardest state to reach is a returned word parked in the engine while the FIFO refuses it. This needs a read to be accepted exactly while the FIFO had room, followed by a full FIFO. The bench opens `fifo_ready` for a single cycle and then closes it. It then drops `enable` in that parked state to show that the word is abandoned. A bus abort on a chosen read in the middle of a buffer is reached by having the bench memory model fail a selected read index. Random runs mix throttled request and FIFO readiness over many buffer lengths.

// File: rtl/bufrd_pkg.sv
package bufrd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_PUSH,
    ST_HALT
  } eng_st_e;

  localparam int unsigned STAT_W   = 32;
  localparam int unsigned BIT_TERM = 20;
  localparam int unsigned BIT_ERR  = 18;
  localparam int unsigned BIT_BUSY = 17;
  localparam int unsigned BIT_IDLE = 16;

  localparam logic [1:0] RSP_OK     = 2'b00;
  localparam logic [1:0] RSP_NOTGT  = 2'b01;
  localparam logic [1:0] RSP_TGTERR = 2'b10;
endpackage

// File: rtl/bufrd_walker.sv
module bufrd_walker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              load,
  input  logic [LEN_W-1:0]  len_in,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP);
  localparam logic [LEN_W-1:0]  ONE = LEN_W'(1);

  logic [ADDR_W-1:0] base_q, addr_q;
  logic [LEN_W-1:0]  rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      addr_q <= '0;
      rem_q  <= '0;
    end else begin
      if (base_we) base_q <= base_in;
      if (load) begin
        addr_q <= base_q;
        rem_q  <= len_in;
      end else if (step) begin
        addr_q <= addr_q + INC;
        rem_q  <= rem_q - ONE;
      end
    end
  end

  assign addr = addr_q;
  assign last = (rem_q == '0);

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> addr == $past(addr) + INC);
endmodule

// File: rtl/bufrd_fsm.sv
module bufrd_fsm
  import bufrd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              len_we,
  input  logic              len_zero,
  input  logic              done,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [1:0]        rsp_err,
  input  logic              fifo_ready,
  output logic              req_valid,
  output logic              rsp_ready,
  output logic              fifo_valid,
  output logic [DATA_W-1:0] fifo_data,
  output logic              load,
  output logic              step,
  output logic              ev_term,
  output logic              ev_err,
  output logic              busy,
  output logic              idle
);
  eng_st_e           st_q;
  logic [DATA_W-1:0] hold_q;
  logic              rsp_take, push;

  assign load      = enable && len_we && (st_q == ST_IDLE);
  assign req_valid = (st_q == ST_REQ) && fifo_ready;
  assign step      = req_valid && req_ready;
  assign rsp_ready = (st_q == ST_WAIT);
  assign rsp_take  = rsp_ready && rsp_valid;
  assign fifo_valid = (st_q == ST_PUSH);
  assign fifo_data  = hold_q;
  assign push       = fifo_valid && fifo_ready;
  assign ev_term    = enable && ((load && len_zero) || (push && done));
  assign ev_err     = enable && rsp_take && (rsp_err != RSP_OK);
  assign busy       = (st_q == ST_REQ) || (st_q == ST_WAIT) || (st_q == ST_PUSH);
  assign idle       = (st_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hold_q <= '0;
    end else if (!enable) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (load) st_q <= len_zero ? ST_IDLE : ST_REQ;
        ST_REQ:  if (step) st_q <= ST_WAIT;
        ST_WAIT: if (rsp_take) begin
          if (rsp_err != RSP_OK) st_q <= ST_HALT;
          else begin
            st_q   <= ST_PUSH;
            hold_q <= rsp_data;
          end
        end
        ST_PUSH: if (push) st_q <= done ? ST_IDLE : ST_REQ;
        ST_HALT: st_q <= ST_HALT;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r3_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_valid && !fifo_ready && enable |=> fifo_valid && $stable(fifo_data));
  a_r10_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, idle}));
endmodule

// File: rtl/bufrd_status.sv
module bufrd_status
  import bufrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              accept,
  input  logic              ev_term,
  input  logic              ev_err,
  input  logic              busy,
  input  logic              idle,
  output logic [STAT_W-1:0] status
);
  logic term_q, err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      term_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (ev_term)     term_q <= 1'b1;
      else if (accept) term_q <= 1'b0;
      if (!enable)     err_q <= 1'b0;
      else if (ev_err) err_q <= 1'b1;
    end
  end

  always_comb begin
    status           = '0;
    status[BIT_TERM] = term_q;
    status[BIT_ERR]  = err_q;
    status[BIT_BUSY] = busy;
    status[BIT_IDLE] = idle;
  end

  a_r9_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !status[BIT_ERR]);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status[BIT_ERR] && enable |=> status[BIT_ERR]);
  a_r7_term_clear: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !ev_term |=> !status[BIT_TERM]);
endmodule

// File: rtl/bufrd_ctrl.sv
module bufrd_ctrl
  import bufrd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_addr_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_len_we,
  input  logic [LEN_W-1:0]  cfg_len,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  input  logic [1:0]        rd_rsp_err,
  output logic              fifo_valid,
  input  logic              fifo_ready,
  output logic [DATA_W-1:0] fifo_data,
  output logic [31:0]       status
);
  localparam int WORD_BYTES = DATA_W / 8;

  logic load, step, last_word, ev_term, ev_err, busy, idle;

  bufrd_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .STEP(WORD_BYTES)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .base_we(cfg_addr_we), .base_in(cfg_addr),
    .load(load), .len_in(cfg_len), .step(step),
    .addr(rd_req_addr), .last(last_word)
  );

  bufrd_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .len_we(cfg_len_we), .len_zero(cfg_len == '0), .done(last_word),
    .req_ready(rd_req_ready), .rsp_valid(rd_rsp_valid),
    .rsp_data(rd_rsp_data), .rsp_err(rd_rsp_err), .fifo_ready(fifo_ready),
    .req_valid(rd_req_valid), .rsp_ready(rd_rsp_ready),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .load(load), .step(step), .ev_term(ev_term), .ev_err(ev_err),
    .busy(busy), .idle(idle)
  );

  bufrd_status u_stat (
    .clk(clk), .rst_n(rst_n), .enable(enable), .accept(load),
    .ev_term(ev_term), .ev_err(ev_err), .busy(busy), .idle(idle),
    .status(status)
  );

  a_r5_full_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_ready |-> !rd_req_valid);
  a_r6_term_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_valid && fifo_ready && last_word && enable |=> status[BIT_TERM] && status[BIT_IDLE]);
  a_r8_halt_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid && rd_rsp_ready && (rd_rsp_err != RSP_OK) && enable
    |=> status[BIT_ERR] && !rd_req_valid && !status[BIT_BUSY] && !status[BIT_IDLE]);
  a_r9_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> status[BIT_IDLE] && !fifo_valid);
endmodule

// File: tb/bufrd_ctrl_bench.sv
module bufrd_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, enable = 1'b0;
  logic        cfg_addr_we = 1'b0, cfg_len_we = 1'b0;
  logic [31:0] cfg_addr = '0;
  logic [15:0] cfg_len = '0;
  logic        rd_req_valid, rd_req_ready = 1'b0;
  logic [31:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0, rd_rsp_ready;
  logic [31:0] rd_rsp_data = '0;
  logic [1:0]  rd_rsp_err = 2'b00;
  logic        fifo_valid, fifo_ready = 1'b0;
  logic [31:0] fifo_data, status;

  int checks = 0, errors = 0;
  int req_cnt = 0, push_cnt = 0, fifo_pct = 100, req_pct = 100;
  int err_idx = -1, cycles = 0;
  logic [1:0]  err_code = 2'b01;
  logic [31:0] cur_base = '0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  bufrd_ctrl u_bufrd_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_addr_we(cfg_addr_we), .cfg_addr(cfg_addr),
    .cfg_len_we(cfg_len_we), .cfg_len(cfg_len),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
    .fifo_valid(fifo_valid), .fifo_ready(fifo_ready), .fifo_data(fifo_data),
    .status(status)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a ^ {a[15:0], a[31:16]} ^ 32'h5A3C_0F11;
  endfunction

  function automatic logic [31:0] stat_exp(input bit term, input bit err,
                                           input bit busy, input bit idle);
    return {11'd0, term, 1'b0, err, busy, idle, 16'd0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Memory and FIFO model: drives at negedge, observes at negedge+1.
  initial begin : bus_model
    bit pend = 0;
    int dly = 0, pidx = 0;
    logic [31:0] paddr = '0;
    void'($urandom(32'd4242));
    forever begin
      @(negedge clk);
      fifo_ready   = (($urandom % 100) < fifo_pct);
      rd_req_ready = (($urandom % 100) < req_pct);
      if (!enable) pend = 0;
      rd_rsp_valid = 1'b0;
      if (pend) begin
        if (dly > 0) dly--;
        else begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data  = mem_word(paddr);
          rd_rsp_err   = (pidx == err_idx) ? err_code : 2'b00;
        end
      end
      #1;
      if (rd_rsp_valid && rd_rsp_ready) pend = 0;
      if (rd_req_valid && rd_req_ready) begin
        check("R3 address", rd_req_addr, cur_base + 32'(4 * req_cnt));
        paddr = rd_req_addr; pidx = req_cnt; pend = 1; dly = $urandom % 3;
        req_cnt++;
      end
      if (fifo_valid && fifo_ready) begin
        check("R4 data order", fifo_data, mem_word(cur_base + 32'(4 * push_cnt)));
        push_cnt++;
      end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic start_buf(input logic [31:0] base, input logic [15:0] len);
    cfg_addr_we = 1; cfg_addr = base; tick();
    cfg_addr_we = 0; cfg_len_we = 1; cfg_len = len;
    cur_base = base; req_cnt = 0; push_cnt = 0; tick();
    cfg_len_we = 0;
  endtask

  task automatic wait_idle(input int limit);
    for (int i = 0; i < limit && !status[16]; i++) tick();
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 150000 && !done_flag) begin
        errors++; checks++;
        $display("FAIL R1 watchdog actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin : main
    tick(4);
    rst_n = 1; tick();
    check("R1 reset status", status, stat_exp(0, 0, 0, 1));
    check("R1 no fifo word", {31'd0, fifo_valid}, 32'd0);

    // R2: count write while disabled ignored
    start_buf(32'h0000_0800, 16'd5);
    check("R2 disabled write", status, stat_exp(0, 0, 0, 1));
    tick(8);
    check("R2 no reads when disabled", req_cnt, 0);

    enable = 1; tick();
    start_buf(32'h0000_1000, 16'd4);
    check("R2 busy after start", status, stat_exp(0, 0, 1, 0));
    wait_idle(200);
    check("R6 word count", push_cnt, 4);
    check("R3 read count", req_cnt, 4);
    check("R6 R10 done status", status, stat_exp(1, 0, 0, 1));

    // R7: new buffer clears term
    start_buf(32'h0000_2000, 16'd3);
    check("R7 term cleared", status, stat_exp(0, 0, 1, 0));
    wait_idle(200);
    check("R6 second buffer", push_cnt, 3);

    // R2: count write while busy ignored
    fifo_pct = 50;
    start_buf(32'h0000_3000, 16'd6);
    tick(2);
    cfg_len_we = 1; cfg_len = 16'd40; tick(); cfg_len_we = 0;
    wait_idle(400);
    check("R2 busy write ignored", push_cnt, 6);
    fifo_pct = 100;

    // R7: zero length
    start_buf(32'h0000_3800, 16'd0);
    check("R7 zero length term", status, stat_exp(1, 0, 0, 1));
    tick(5);
    check("R7 zero length no reads", req_cnt, 0);

    // R5 / R4: parked word while FIFO full
    fifo_pct = 0;
    start_buf(32'h0000_4000, 16'd5);
    tick(6);
    check("R5 no read while full", req_cnt, 0);
    fifo_pct = 100; tick(); fifo_pct = 0;
    tick(10);
    check("R5 one read then stop", req_cnt, 1);
    check("R4 word held", {31'd0, fifo_valid}, 32'd1);
    check("R4 held data", fifo_data, mem_word(32'h0000_4000));
    enable = 0; tick();
    check("R9 disable to idle", status, stat_exp(0, 0, 0, 1));
    check("R9 word dropped", {31'd0, fifo_valid}, 32'd0);
    enable = 1; fifo_pct = 100; tick(5);
    check("R9 nothing pushed", push_cnt, 0);

    // R8: abort on read index 2
    err_idx = 2; err_code = 2'b01;
    start_buf(32'h0000_5000, 16'd8);
    tick(25);
    check("R8 no-target halt", status, stat_exp(0, 1, 0, 0));
    check("R8 reads stopped", req_cnt, 3);
    cfg_len_we = 1; cfg_len = 16'd2; tick(); cfg_len_we = 0; tick(3);
    check("R2 R8 halted write ignored", status, stat_exp(0, 1, 0, 0));
    enable = 0; tick();
    check("R9 error cleared", status, stat_exp(0, 0, 0, 1));
    enable = 1; tick();
    err_idx = 0; err_code = 2'b10;
    start_buf(32'h0000_6000, 16'd4);
    tick(10);
    check("R8 target error halt", status, stat_exp(0, 1, 0, 0));
    check("R8 single read", req_cnt, 1);
    enable = 0; tick(); enable = 1; err_idx = -1; tick();

    // Random buffers
    for (int b = 0; b < 14; b++) begin
      int len;
      len = 1 + ($urandom % 24);
      fifo_pct = 20 + ($urandom % 81);
      req_pct  = 30 + ($urandom % 71);
      start_buf($urandom & 32'hFFFF_FFFC, 16'(len));
      wait_idle(3000);
      check("R6 random count", push_cnt, len);
      check("R10 random status", status, stat_exp(1, 0, 0, 1));
    end

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule